// File: doc/BRIEF.md
# Dual-Period Programmable Waveform Timer

This block drives one output pin with a repeating two-phase waveform. An 8-bit down-counter first counts out a programmable primary period and then a programmable secondary period, then starts over. The pin level differs between the two phases. A polarity bit picks which phase is high, and it also sets the level the pin rests at while the timer is halted. The counter moves only on cycles where the prescaled tick enable is high.

Software reaches the block through a small register port. Two registers hold control and output settings. Two registers hold the reload values for the primary and secondary periods. One read-only register returns the live count. A primary reload value written while the timer is running goes only into its reload register. The same write made while the timer is halted also loads the live counter, which sets the length of the first primary period after the next start. A one-cycle underflow strobe marks the end of each secondary period, so software can pace updates to the waveform.

Top module: `dpwTimer`

## Requirements
- R1: Synchronous active-high reset clears every register and the counter to 0. After reset the output is low, the underflow strobe is low, and every read address returns 0.
- R2: Address 0 is the control register: bit 0 start flag, bit 1 write-control flag, bits 3:2 mode field. Address 1 is the output register: bit 0 polarity, bit 1 trigger enable, bit 2 trigger polarity. Bits that are not listed here read as 0, and writing them has no effect. The write-control and trigger bits are stored and read back but do not change the timer's behaviour.
- R3: The timer runs only while the start flag is 1 and the mode field is 01. In every other case the counter ignores the tick enable and holds its value.
- R4: With polarity 0 and the timer running, the output is high during the primary phase and low during the secondary phase.
- R5: With polarity 1 and the timer running, the output is low during the primary phase and high during the secondary phase.
- R6: While the timer is halted, the output equals the polarity bit.
- R7: Address 2 holds the primary reload value and address 3 the secondary reload value. Both read back what was last written. A write to address 2 while the timer runs changes only the reload value and leaves the counter alone.
- R8: A write to address 2 while the timer is halted stores the value and also loads it into the counter. A write to address 3 never touches the counter.
- R9: While running, each tick decrements a non-zero count by 1. A tick at count 0 ends the phase: the primary phase reloads the counter from the secondary reload value, and the secondary phase reloads it from the primary reload value.
- R10: Every start begins in the primary phase, using the counter's current value. Halting the timer returns it to the primary phase.
- R11: The underflow strobe is high for exactly the one cycle that follows the tick ending a secondary period. It is never high on two cycles in a row.
- R12: Address 4 returns the live count. Addresses 5 to 7 read as 0. Writes to addresses 4 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Prescaled count enable, one cycle per count |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Read data for rdAddr, combinational |
| waveOut | output | 1 | Waveform output pin |
| underflow | output | 1 | One-cycle strobe at the end of each secondary period |

## Verification
The assertions assume a single write port with at most one write per cycle. They also assume that a write landing on the same edge as a tick takes effect in the registers only after that edge, so any reload that edge performs still uses the old value. The random stimulus issues at most one write per step. It steers most control writes to mode 01 with the start flag set, so that long running stretches cross many underflows, and it mixes in halts, other mode codes, writes to unused addresses and reload changes in both run states. The bench model applies the same edge semantics, so a write and a tick falling on the same cycle are still checked.

// File: rtl/dpwTimerPkg.sv
package dpwTimerPkg;
  localparam int AddrW = 3;
  localparam logic [AddrW-1:0] AddrCtrl = 3'd0;
  localparam logic [AddrW-1:0] AddrOut  = 3'd1;
  localparam logic [AddrW-1:0] AddrPri  = 3'd2;
  localparam logic [AddrW-1:0] AddrSec  = 3'd3;
  localparam logic [AddrW-1:0] AddrCnt  = 3'd4;
  localparam logic [1:0] ModeWave = 2'b01;
  localparam int CtrlBits = 4;
  localparam int OutBits  = 3;

  typedef struct packed {
    logic run;
    logic loadCnt;
    logic polarity;
  } tmrStrobe_t;
endpackage

// File: rtl/dpwTimerCtrl.sv
module dpwTimerCtrl
  import dpwTimerPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddr,
  input  logic [DataW-1:0] cntVal,
  output logic [DataW-1:0] rdData,
  output logic [DataW-1:0] priRel,
  output logic [DataW-1:0] secRel,
  output tmrStrobe_t       strb
);
  localparam int CtrlPad = DataW - CtrlBits;
  localparam int OutPad  = DataW - OutBits;

  logic [CtrlBits-1:0] ctrlReg;
  logic [OutBits-1:0]  outReg;
  logic                runNow;

  assign runNow = ctrlReg[0] && (ctrlReg[3:2] == ModeWave);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      outReg  <= '0;
      priRel  <= '0;
      secRel  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        AddrCtrl: ctrlReg <= wrData[CtrlBits-1:0];
        AddrOut:  outReg  <= wrData[OutBits-1:0];
        AddrPri:  priRel  <= wrData;
        AddrSec:  secRel  <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.run      = runNow;
    strb.loadCnt  = wrEn && (wrAddr == AddrPri) && !runNow;
    strb.polarity = outReg[0];
  end

  always_comb begin
    case (rdAddr)
      AddrCtrl: rdData = {{CtrlPad{1'b0}}, ctrlReg};
      AddrOut:  rdData = {{OutPad{1'b0}}, outReg};
      AddrPri:  rdData = priRel;
      AddrSec:  rdData = secRel;
      AddrCnt:  rdData = cntVal;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dpwTimerDp.sv
module dpwTimerDp
  import dpwTimerPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  tmrStrobe_t       strb,
  input  logic [DataW-1:0] loadVal,
  input  logic [DataW-1:0] priRel,
  input  logic [DataW-1:0] secRel,
  output logic [DataW-1:0] cntVal,
  output logic             waveOut,
  output logic             underflow
);
  logic phaseSec;
  logic cntZero;

  assign cntZero = (cntVal == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal    <= '0;
      phaseSec  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= 1'b0;
      if (!strb.run) begin
        phaseSec <= 1'b0;
        if (strb.loadCnt) cntVal <= loadVal;
      end else if (tickEn) begin
        if (!cntZero) begin
          cntVal <= cntVal - 1'b1;
        end else if (phaseSec) begin
          cntVal    <= priRel;
          phaseSec  <= 1'b0;
          underflow <= 1'b1;
        end else begin
          cntVal   <= secRel;
          phaseSec <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!strb.run) waveOut = strb.polarity;
    else if (phaseSec) waveOut = strb.polarity;
    else waveOut = !strb.polarity;
  end
endmodule

// File: rtl/dpwTimer.sv
module dpwTimer
  import dpwTimerPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [DataW-1:0] rdData,
  output logic             waveOut,
  output logic             underflow
);
  tmrStrobe_t       strb;
  logic [DataW-1:0] priRel;
  logic [DataW-1:0] secRel;
  logic [DataW-1:0] cntVal;

  dpwTimerCtrl #(.DataW(DataW)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .cntVal(cntVal), .rdData(rdData),
    .priRel(priRel), .secRel(secRel), .strb(strb)
  );

  dpwTimerDp #(.DataW(DataW)) u_dp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .strb(strb), .loadVal(wrData),
    .priRel(priRel), .secRel(secRel), .cntVal(cntVal),
    .waveOut(waveOut), .underflow(underflow)
  );
endmodule

// File: rtl/dpwTimerChk.sv
module dpwTimerChk #(
  parameter int DataW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [DataW-1:0] wrData,
  input logic             running,
  input logic             polarity,
  input logic [DataW-1:0] count,
  input logic             waveOut,
  input logic             underflow
);
  logic priWr;
  assign priWr = wrEn && (wrAddr == 3'd2);

  p_uflow_single_r11: assert property (@(posedge clk) disable iff (rst)
    underflow |=> !underflow);

  p_count_dec_r9: assert property (@(posedge clk) disable iff (rst)
    running && tickEn && (count != '0) |=> count == $past(count) - 1'b1);

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    !running && !priWr |=> $stable(count));

  p_load_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    !running && priWr |=> count == $past(wrData));

  p_run_write_r7: assert property (@(posedge clk) disable iff (rst)
    running && !tickEn && priWr |=> $stable(count));

  p_restart_primary_r10: assert property (@(posedge clk) disable iff (rst)
    underflow && running |-> waveOut != polarity);

  p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
    !running && $past(!running) |-> waveOut == polarity);
endmodule

bind dpwTimer dpwTimerChk #(.DataW(DataW)) u_chk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .running(strb.run), .polarity(strb.polarity),
  .count(cntVal), .waveOut(waveOut), .underflow(underflow)
);

// File: tb/dpwTimer_tb.sv
module dpwTimer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       waveOut;
  logic       underflow;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dpwTimer u_dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .waveOut(waveOut), .underflow(underflow)
  );

  // Model state after the last edge, and the state due at the next edge.
  logic [3:0] mCtrl = '0, nCtrl = '0;
  logic [2:0] mOut = '0, nOut = '0;
  logic [7:0] mPri = '0, nPri = '0, mSec = '0, nSec = '0, mCnt = '0, nCnt = '0;
  logic       mPh = 1'b0, nPh = 1'b0, mUf = 1'b0, nUf = 1'b0;
  logic       prevRun = 1'b0;
  bit         firstStep = 1'b1;
  bit         inResetCheck = 1'b0;

  function automatic logic runOf(input logic [3:0] c);
    return c[0] && (c[3:2] == 2'b01);
  endfunction

  function automatic logic [7:0] readModel(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, mCtrl};
      3'd1: return {5'b0, mOut};
      3'd2: return mPri;
      3'd3: return mSec;
      3'd4: return mCnt;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic waveModel();
    if (!runOf(mCtrl)) return mOut[0];
    return mPh ? mOut[0] : !mOut[0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    string wTag, rTag, uTag;
    logic  run;
    run = runOf(mCtrl);
    if (inResetCheck) begin
      wTag = "R1 output"; rTag = "R1 readback"; uTag = "R1 underflow";
    end else begin
      if (!run) wTag = "R6 idle level";
      else if (!prevRun) wTag = "R10 start in primary";
      else if (mOut[0]) wTag = "R5 inverted wave";
      else wTag = "R4 normal wave";
      uTag = "R11 underflow";
      case (rdAddr)
        3'd0, 3'd1: rTag = "R2 register";
        3'd2, 3'd3: rTag = "R7 reload";
        3'd4: rTag = run ? "R9 count" : ((mCtrl[0] && mCtrl[3:2] != 2'b01) ? "R3 hold" : "R8 count");
        default: rTag = "R12 unused address";
      endcase
    end
    check(waveOut === waveModel(), wTag, waveOut, waveModel());
    check(underflow === mUf, uTag, underflow, mUf);
    check(rdData === readModel(rdAddr), rTag, rdData, readModel(rdAddr));
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                      input logic tk, input logic [2:0] ra);
    logic run;
    @(negedge clk);
    prevRun = runOf(mCtrl);
    mCtrl = nCtrl; mOut = nOut; mPri = nPri; mSec = nSec;
    mCnt = nCnt; mPh = nPh; mUf = nUf;
    if (!firstStep) checkAll();
    firstStep = 1'b0;
    wrEn = we; wrAddr = wa; wrData = wd; tickEn = tk; rdAddr = ra;
    // next state at the coming edge
    run = runOf(mCtrl);
    nCtrl = mCtrl; nOut = mOut; nPri = mPri; nSec = mSec;
    nCnt = mCnt; nPh = mPh; nUf = 1'b0;
    if (rst) begin
      nCtrl = '0; nOut = '0; nPri = '0; nSec = '0; nCnt = '0; nPh = 1'b0;
    end else begin
      if (!run) begin
        nPh = 1'b0;
        if (we && wa == 3'd2) nCnt = wd;
      end else if (tk) begin
        if (mCnt != 0) nCnt = mCnt - 8'd1;
        else if (mPh) begin nCnt = mPri; nPh = 1'b0; nUf = 1'b1; end
        else begin nCnt = mSec; nPh = 1'b1; end
      end
      if (we) begin
        case (wa)
          3'd0: nCtrl = wd[3:0];
          3'd1: nOut = wd[2:0];
          3'd2: nPri = wd;
          3'd3: nSec = wd;
          default: ;
        endcase
      end
    end
  endtask

  task automatic ticks(input int n, input logic [2:0] ra);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b1, ra);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    rst = 1'b0;
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    // R1: reset state on every address
    inResetCheck = 1'b1;
    for (int a = 0; a < 8; a++) step(1'b0, 3'd0, 8'h00, 1'b1, 3'(a));
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd4);
    inResetCheck = 1'b0;
    // R8: stopped write to primary reload loads counter; secondary does not
    step(1'b1, 3'd2, 8'd3, 1'b0, 3'd4);
    step(1'b1, 3'd3, 8'd1, 1'b0, 3'd4);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'd4);
    // R2: reserved bits dropped on write
    step(1'b1, 3'd0, 8'hF2, 1'b0, 3'd0);
    step(1'b1, 3'd1, 8'hF8, 1'b0, 3'd1);
    // R3: start with wrong mode holds counter
    step(1'b1, 3'd0, 8'h0B, 1'b1, 3'd4);
    ticks(4, 3'd4);
    // R4, R9, R10, R11: start mode 01 with write-control set
    step(1'b1, 3'd0, 8'h07, 1'b1, 3'd4);
    ticks(14, 3'd4);
    // R7: change primary reload while running
    step(1'b1, 3'd2, 8'd5, 1'b0, 3'd2);
    step(1'b1, 3'd2, 8'd2, 1'b1, 3'd4);
    ticks(12, 3'd4);
    // R5: polarity 1 while running, then halt for R6
    step(1'b1, 3'd1, 8'h01, 1'b1, 3'd1);
    ticks(10, 3'd4);
    step(1'b1, 3'd0, 8'h06, 1'b1, 3'd4);
    ticks(3, 3'd4);
    // R12: writes to unused addresses ignored
    for (int a = 4; a < 8; a++) step(1'b1, 3'(a), 8'hA5, 1'b0, 3'(a));
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd4);
    // R10: restart with zero count from stopped
    step(1'b1, 3'd2, 8'd0, 1'b0, 3'd4);
    step(1'b1, 3'd3, 8'd0, 1'b0, 3'd4);
    step(1'b1, 3'd0, 8'h05, 1'b1, 3'd4);
    ticks(8, 3'd4);
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic       we;
      logic [2:0] wa;
      logic [7:0] wd;
      we = ($urandom_range(0, 99) < 15);
      wa = 3'($urandom_range(0, 7));
      wd = 8'($urandom);
      if (wa == 3'd0 && $urandom_range(0, 9) < 8)
        wd = {4'($urandom), 2'b01, 1'b1, 1'($urandom_range(0, 9) < 8)};
      if ((wa == 3'd2 || wa == 3'd3) && $urandom_range(0, 1) == 0)
        wd = 8'($urandom_range(0, 6));
      step(we, wa, wd, 1'($urandom_range(0, 9) < 7), 3'($urandom_range(0, 7)));
    end
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule